// File: doc/BRIEF.md
# Wilkinson Conversion Gate Sequencer

This block sequences one channel of a charge-to-time converter. A rising edge on the discriminator hit input opens an integrate gate for a programmed number of clock cycles. When the gate closes, the sequencer raises a rundown enable that starts the constant-current discharge of the hold capacitor. The rundown enable stays high until the hold-capacitor comparator reports a zero crossing. The width of the rundown pulse is the channel's output and encodes the collected charge. A programmable timeout ends a rundown whose zero crossing never arrives and sets a sticky error flag.

A dead-time window is counted from each accepted hit. Until it has expired, and until the gate and rundown are over, further hit edges are ignored. This keeps late pulses from the same track from starting new cycles. Both asynchronous inputs pass through two-flop synchronizers, and edges are detected after synchronization. The gate length and dead time are loaded into their counters when a hit is accepted. The timeout is latched at the same moment, so configuration changes never disturb a conversion in progress.

The state machine has four states: IDLE, GATE, RUNDOWN and HOLDOFF. The transitions are:
- IDLE to GATE on an accepted hit edge.
- GATE to RUNDOWN when the gate count is used up.
- RUNDOWN to IDLE or to HOLDOFF on a zero edge or a timeout. It goes to HOLDOFF when dead time still remains.
- HOLDOFF to IDLE when the dead time expires.

Top module: `wilk_gate_seq`

## Requirements
- R1: A rising edge of `hit_in` is accepted only in IDLE. Because of the two-flop synchronizer and edge detector, `gate_o` rises at the third clock edge after `hit_in` is raised.
- R2: `gate_o` stays high for exactly `cfg_gate` cycles, with a value of 0 treated as 1. `rundown_o` rises on the same edge on which `gate_o` falls.
- R3: `rundown_o` falls at the third clock edge after `zero_in` rises. A rising `zero_in` outside RUNDOWN has no effect on any output.
- R4: `busy_o` rises with `gate_o` and stays high for max(`cfg_dead`, gate cycles + rundown cycles) cycles. Hit edges arriving while `busy_o` is high start no new cycle.
- R5: A rundown that receives no zero edge ends after `cfg_tmo` cycles, with 0 treated as 1. In that case `err_o` is set and stays set until reset. A zero edge in the last allowed cycle ends the rundown normally.
- R6: A `zero_in` level that is already high when RUNDOWN begins has no edge, so it does not end the rundown.
- R7: Changes to `cfg_gate`, `cfg_dead` and `cfg_tmo` take effect only at the next accepted hit. A conversion in progress keeps the values captured at its own hit.
- R8: A synchronous `rst` returns the sequencer to IDLE and clears all outputs, including `err_o`, from the next clock edge onward.
- R9: `gate_o` and `rundown_o` are never high together, and either of them being high implies `busy_o`.
- R10: A `hit_in` held high past the end of `busy_o` does not retrigger. Only a new rising edge starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_in | input | 1 | Discriminator hit, asynchronous |
| zero_in | input | 1 | Hold-capacitor zero-crossing sense, asynchronous |
| cfg_gate | input | GATE_W | Integrate gate length in cycles |
| cfg_dead | input | DEAD_W | Dead time from accepted hit, in cycles |
| cfg_tmo | input | TMO_W | Rundown timeout in cycles |
| gate_o | output | 1 | Integrate gate |
| rundown_o | output | 1 | Rundown enable and pulse-width channel output |
| busy_o | output | 1 | Sequencer busy, hits inhibited |
| err_o | output | 1 | Sticky rundown-timeout flag |

## Verification
The main function is swept over every gate length from 0 to 3, three timeouts (including 0), zero-edge delays from 0 to 4 cycles and three dead times.

The sweep separates several cases:
- Rundowns ended by the comparator from rundowns ended by the timeout, including the tie at the last allowed cycle.
- A busy window set by the dead time from one set by gate plus rundown.

Further patterns cover:
- Zero edges in IDLE and a zero level held from before the rundown, which show that edge detection gates the comparator.
- Hit edges toggled during a long dead time, and a hit held high past busy, which tell retrigger inhibit apart from level sensitivity.
- A configuration change in mid-conversion, and a reset in mid-conversion.

// File: rtl/wgs_pkg.sv
package wgs_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_GATE,
        S_RUNDOWN,
        S_HOLDOFF
    } seq_state_t;
endpackage

// File: rtl/wgs_sync.sv
module wgs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] rise_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // STAGES synchronizer flops plus one delay flop for edge detection
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-1:0], d_in[b]};
        end
        assign rise_o[b] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/wgs_dead_timer.sv
module wgs_dead_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] left_o,
    output logic         last_o
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)               left_q <= '0;
        else if (load)         left_q <= load_val;
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign left_o = left_q;
    // one or zero cycles of dead time remain after this edge
    assign last_o = (left_q <= W'(1));

    // R4: once expired the window stays expired until the next accepted hit
    p_dead_sat_r4: assert property (@(posedge clk) disable iff (rst)
        (left_q == '0 && !load) |=> (left_q == '0));
endmodule

// File: rtl/wilk_gate_seq.sv
module wilk_gate_seq
    import wgs_pkg::*;
#(
    parameter int GATE_W = 4,
    parameter int DEAD_W = 9,
    parameter int TMO_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_in,
    input  logic              zero_in,
    input  logic [GATE_W-1:0] cfg_gate,
    input  logic [DEAD_W-1:0] cfg_dead,
    input  logic [TMO_W-1:0]  cfg_tmo,
    output logic              gate_o,
    output logic              rundown_o,
    output logic              busy_o,
    output logic              err_o
);
    localparam int SYNC_STAGES = 2;
    localparam int SIG_HIT  = 0;
    localparam int SIG_ZERO = 1;

    seq_state_t state_q, state_d;

    logic [1:0]        rise;
    logic              hit_rise, zero_rise;
    logic              accept, tmo_hit;
    logic [GATE_W-1:0] gate_eff, gcnt_q;
    logic [TMO_W-1:0]  tmo_eff, tmo_q, tcnt_q;
    logic [DEAD_W-1:0] dead_left;
    logic              dead_last;
    logic              err_q;

    wgs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_in   ({zero_in, hit_in}),
        .rise_o (rise)
    );
    assign hit_rise  = rise[SIG_HIT];
    assign zero_rise = rise[SIG_ZERO];

    assign accept   = (state_q == S_IDLE) && hit_rise;
    assign gate_eff = (cfg_gate == '0) ? GATE_W'(1) : cfg_gate;
    assign tmo_eff  = (cfg_tmo == '0) ? TMO_W'(1) : cfg_tmo;
    assign tmo_hit  = (state_q == S_RUNDOWN) && !zero_rise
                      && (tcnt_q == tmo_q - 1'b1);

    wgs_dead_timer #(.W(DEAD_W)) u_dead (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cfg_dead),
        .left_o   (dead_left),
        .last_o   (dead_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_GATE;
            S_GATE:    if (gcnt_q == '0) state_d = S_RUNDOWN;
            S_RUNDOWN: if (zero_rise || tmo_hit)
                           state_d = dead_last ? S_IDLE : S_HOLDOFF;
            S_HOLDOFF: if (dead_last) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // counters, captured configuration and error flag
    always_ff @(posedge clk) begin
        if (rst) begin
            gcnt_q <= '0;
            tcnt_q <= '0;
            tmo_q  <= TMO_W'(1);
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                gcnt_q <= gate_eff - 1'b1;
                tmo_q  <= tmo_eff;
            end else if (state_q == S_GATE && gcnt_q != '0) begin
                gcnt_q <= gcnt_q - 1'b1;
            end
            if (state_q == S_RUNDOWN) tcnt_q <= tcnt_q + 1'b1;
            else                      tcnt_q <= '0;
            if (tmo_hit) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        gate_o    = (state_q == S_GATE);
        rundown_o = (state_q == S_RUNDOWN);
        busy_o    = (state_q != S_IDLE);
        err_o     = err_q;
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && hit_rise) |=> gate_o);

    p_gate_end_r2: assert property (@(posedge clk) disable iff (rst)
        (gate_o && gcnt_q == '0) |=> (rundown_o && !gate_o));

    p_zero_end_r3: assert property (@(posedge clk) disable iff (rst)
        (rundown_o && zero_rise) |=> !rundown_o);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !hit_rise) |=> !busy_o);

    p_holdoff_dead_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HOLDOFF) |-> (dead_left != '0));

    p_tmo_cap_r5: assert property (@(posedge clk) disable iff (rst)
        rundown_o |-> (tcnt_q < tmo_q));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(gate_o && rundown_o));

    p_busy_cover_r9: assert property (@(posedge clk) disable iff (rst)
        (gate_o || rundown_o) |-> busy_o);
endmodule

// File: tb/wilk_gate_seq_tb_top.sv
`timescale 1ns/1ps
module wilk_gate_seq_tb_top;
    localparam int GATE_W = 4;
    localparam int DEAD_W = 9;
    localparam int TMO_W  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_in = 1'b0;
    logic zero_in = 1'b0;
    logic [GATE_W-1:0] cfg_gate = GATE_W'(1);
    logic [DEAD_W-1:0] cfg_dead = '0;
    logic [TMO_W-1:0]  cfg_tmo = TMO_W'(4);
    logic gate_o, rundown_o, busy_o, err_o;

    always #2.5 clk = ~clk;

    wilk_gate_seq #(.GATE_W(GATE_W), .DEAD_W(DEAD_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst(rst), .hit_in(hit_in), .zero_in(zero_in),
        .cfg_gate(cfg_gate), .cfg_dead(cfg_dead), .cfg_tmo(cfg_tmo),
        .gate_o(gate_o), .rundown_o(rundown_o), .busy_o(busy_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit err_model = 1'b0;

    // pulse-width monitor
    int g_run = 0, r_run = 0, b_run = 0;
    int g_last = 0, r_last = 0, b_last = 0;
    int g_starts = 0, overlap = 0;
    bit g_prev = 1'b0;

    always @(negedge clk) begin
        if (gate_o && rundown_o) overlap++;
        if ((gate_o || rundown_o) && !busy_o) overlap++;
        if (gate_o && !g_prev) g_starts++;
        g_prev = gate_o;
        if (gate_o) g_run++;
        else if (g_run != 0) begin g_last = g_run; g_run = 0; end
        if (rundown_o) r_run++;
        else if (r_run != 0) begin r_last = r_run; r_run = 0; end
        if (busy_o) b_run++;
        else if (b_run != 0) begin b_last = b_run; b_run = 0; end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic run_conv(input int g, input int d, input int t, input int zd,
                            input bit zero_pre);
        int s0, lat, ge, te, r;
        bit tmo;
        cfg_gate = GATE_W'(g);
        cfg_dead = DEAD_W'(d);
        cfg_tmo  = TMO_W'(t);
        zero_in  = zero_pre;
        hit_in   = 1'b0;
        repeat (4) @(negedge clk);
        s0 = g_starts;
        hit_in = 1'b1;
        lat = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            lat++;
            if (gate_o) break;
        end
        for (int i = 0; i < 50; i++) begin
            if (rundown_o) break;
            @(negedge clk);
        end
        hit_in = 1'b0;
        repeat (zd) @(negedge clk);
        zero_in = 1'b1;
        wait_idle();
        zero_in = 1'b0;
        repeat (5) @(negedge clk);
        ge  = (g == 0) ? 1 : g;
        te  = (t == 0) ? 1 : t;
        tmo = zero_pre || (zd + 3 > te);
        r   = zero_pre ? te : imin(zd + 3, te);
        if (tmo) err_model = 1'b1;
        chk("R1 hit-to-gate latency", lat, 3);
        chk("R2 gate width", g_last, ge);
        if (zero_pre) chk("R6 rundown width with zero pre-high", r_last, r);
        else if (tmo) chk("R5 rundown width at timeout", r_last, r);
        else          chk("R3 rundown width from zero edge", r_last, r);
        chk("R4 busy width", b_last, imax(d, ge + r));
        chk("R4 one cycle per hit", g_starts - s0, 1);
        chk("R5 sticky error flag", int'(err_o), int'(err_model));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, ge;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk("R8 reset gate", int'(gate_o), 0);
        chk("R8 reset rundown", int'(rundown_o), 0);
        chk("R8 reset busy", int'(busy_o), 0);
        chk("R8 reset err", int'(err_o), 0);

        // sweep of gate, timeout, zero delay and dead time
        for (int g = 0; g < 4; g++)
            for (int ti = 0; ti < 3; ti++)
                for (int zd = 0; zd < 5; zd++)
                    for (int di = 0; di < 3; di++)
                        run_conv(g, (di == 0) ? 0 : (di == 1) ? 5 : 12,
                                 (ti == 0) ? 0 : (ti == 1) ? 4 : 6, zd, 1'b0);

        // R3: zero edge in IDLE has no effect
        zero_in = 1'b1;
        repeat (8) @(negedge clk);
        chk("R3 zero in idle leaves rundown low", int'(rundown_o), 0);
        chk("R3 zero in idle leaves busy low", int'(busy_o), 0);
        zero_in = 1'b0;
        repeat (4) @(negedge clk);

        // R6: zero level already high before rundown
        run_conv(2, 0, 5, 0, 1'b1);
        run_conv(1, 20, 3, 1, 1'b1);

        // R4: late hit edges inside a long dead time
        cfg_gate = GATE_W'(2); cfg_dead = DEAD_W'(40); cfg_tmo = TMO_W'(8);
        repeat (4) @(negedge clk);
        s0 = g_starts;
        hit_in = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rundown_o) break;
        end
        hit_in = 1'b0;
        repeat (2) @(negedge clk);
        hit_in = 1'b1;
        repeat (2) @(negedge clk);
        hit_in = 1'b0;
        zero_in = 1'b1;
        repeat (12) @(negedge clk);
        hit_in = 1'b1;
        repeat (3) @(negedge clk);
        hit_in = 1'b0;
        wait_idle();
        zero_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 late hits ignored", g_starts - s0, 1);
        chk("R4 busy equals dead time", b_last, 40);
        chk("R3 rundown width late-hit case", r_last, 7);

        // R10: hit held high past busy
        cfg_dead = DEAD_W'(0); cfg_tmo = TMO_W'(3);
        repeat (4) @(negedge clk);
        s0 = g_starts;
        hit_in = 1'b1;
        repeat (3) @(negedge clk);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R10 held hit no retrigger", g_starts - s0, 1);
        chk("R10 idle while hit held", int'(busy_o), 0);
        hit_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7: configuration change mid-conversion
        cfg_gate = GATE_W'(3); cfg_dead = DEAD_W'(12); cfg_tmo = TMO_W'(6);
        repeat (4) @(negedge clk);
        hit_in = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (gate_o) break;
        end
        cfg_gate = GATE_W'(1); cfg_dead = DEAD_W'(0); cfg_tmo = TMO_W'(2);
        for (int i = 0; i < 50; i++) begin
            if (rundown_o) break;
            @(negedge clk);
        end
        hit_in = 1'b0;
        @(negedge clk);
        zero_in = 1'b1;
        wait_idle();
        zero_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 gate kept old length", g_last, 3);
        chk("R7 rundown kept old timeout", r_last, 4);
        chk("R7 busy kept old dead time", b_last, 12);
        run_conv(1, 0, 2, 0, 1'b0);
        ge = 1;
        chk("R7 new settings used next cycle", b_last, ge + 2);

        // R8: reset mid-conversion clears everything including err
        cfg_gate = GATE_W'(3); cfg_dead = DEAD_W'(30); cfg_tmo = TMO_W'(6);
        repeat (4) @(negedge clk);
        hit_in = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (gate_o) break;
        end
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset clears gate", int'(gate_o), 0);
        chk("R8 reset clears rundown", int'(rundown_o), 0);
        chk("R8 reset clears busy", int'(busy_o), 0);
        chk("R8 reset clears err", int'(err_o), 0);
        hit_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        err_model = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 stays idle after reset", int'(busy_o), 0);
        run_conv(2, 0, 6, 1, 1'b0);

        // R9: exclusivity observed over the whole run
        chk("R9 gate/rundown exclusive and covered by busy", overlap, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule